// File: doc/BRIEF.md
# Lowpass Spike Filter for a One-Bit Signal

This block cleans a noisy one-bit signal. On every sample tick the raw bit enters a saturating up/down counter, which works as an integrator. The counter's value is turned back into a bit stream by a rate multiplier. That stream is the sum carry of the counter value and a dither word, and it is fed back as the subtracting input. The result behaves like a first-order RC lowpass: under a steady input the level moves exponentially toward the rail that matches the input.

A hysteresis trigger watches the two top bits of the counter. It sets the output when both bits are 1, clears it when both are 0, and otherwise holds it. Short spikes of either polarity never move the level far enough to cross the trigger band, so they are removed. Long pulses pass through with their width kept, shifted by a roughly fixed delay. The rejection width and the delay grow as two to the power of the counter width, so each extra counter bit doubles them.

The sample enable is a plain strobe and there is no back-pressure. Every strobe consumes one sample, and the output is a level that is valid on every cycle.

Top module: `spike_lpf`

## Requirements
- R1: A synchronous reset clears the integrator, the dither counter and the output to 0. After reset the output needs at least 3·2^(W-2) high samples before it can rise.
- R2: The integrator and the dither counter change only on cycles where `sample_en` is 1. With `sample_en` held at 0, the output stays constant whatever `din` does.
- R3: On a sample tick the integrator goes up by 1 when `din`=1 and the feedback bit is 0. It goes down by 1 when `din`=0 and the feedback bit is 1. In every other case it holds. It never moves by more than 1 per tick.
- R4: The feedback bit is the carry out of the W-bit sum of the integrator value and a dither word. The dither word is the bit-reversed value of a free-running W-bit counter that advances on each sample tick, so its top bit toggles on every tick. An integrator value of 0 never produces feedback.
- R5: The integrator saturates at 2^W-1 and at 0 and never wraps. A high input held for thousands of samples keeps the output at 1, and the output falls within 4·2^W samples once the input goes low.
- R6: The output goes to 1 when the integrator's two top bits are 11 and to 0 when they are 00. For 01 or 10 it holds its value. The output changes one clock after the integrator value that causes the change.
- R7: Once the input has been steady for 8·2^W samples, a spike of the opposite level lasting fewer than 2^(W-2) samples leaves the output unchanged. This holds for positive and for negative spikes.
- R8: A pulse longer than 4·2^W samples produces an output pulse whose width matches the input width within 2^(W-2) samples. The output edge follows the input edge by at most 4·2^W samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; one sample is taken per cycle it is high |
| din | input | 1 | Raw noisy bit |
| dout | output | 1 | Filtered bit from the hysteresis trigger |

## Verification
The bench builds the block with a counter width of 6 instead of 9 and strobes `sample_en` on every second clock. With that width the trigger band, the rejection width (16 samples) and the worst-case delay (256 samples) all fit into short directed runs. Settling to both rails, saturation under a long hold, and width preservation of 300- and 600-sample pulses can then be observed at the output port. The idle clocks between strobes show that the filter ignores the input while no sample is taken.

// File: rtl/spike_lpf_pkg.sv
package spike_lpf_pkg;
  typedef enum logic [1:0] {
    ZONE_LOW  = 2'b00,
    ZONE_MIDL = 2'b01,
    ZONE_MIDH = 2'b10,
    ZONE_HIGH = 2'b11
  } lpf_zone_e;
endpackage

// File: rtl/spike_lpf_dither.sv
module spike_lpf_dither #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_en,
  output logic [W-1:0] dither
);
  logic [W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)            phase_q <= '0;
    else if (sample_en) phase_q <= phase_q + 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dither[i] = phase_q[W-1-i];
  end

  a_r4_msb_toggles: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> (dither[W-1] != $past(dither[W-1])));
  a_r2_dither_idle: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(dither));
endmodule

// File: rtl/spike_lpf_ratemul.sv
module spike_lpf_ratemul #(
  parameter int W = 9
) (
  input  logic [W-1:0] level,
  input  logic [W-1:0] dither,
  output logic         fb
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, level} + {1'b0, dither};
    fb  = sum[W];
  end

  always_comb begin
    if (level == '0) a_r4_empty_no_carry: assert (!fb);
  end
endmodule

// File: rtl/spike_lpf_integ.sv
module spike_lpf_integ #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_en,
  input  logic         din,
  input  logic         fb,
  output logic [W-1:0] level
);
  localparam logic [W-1:0] LVL_MAX = {W{1'b1}};
  localparam logic [W-1:0] LVL_MIN = '0;

  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= LVL_MIN;
    end else if (sample_en) begin
      unique case ({din, fb})
        2'b10:   if (level_q != LVL_MAX) level_q <= level_q + 1'b1;
        2'b01:   if (level_q != LVL_MIN) level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign level = level_q;

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(level_q));
  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> ((level_q == $past(level_q)) ||
                   (level_q == $past(level_q) + 1'b1) ||
                   (level_q == $past(level_q) - 1'b1)));
  a_r3_no_rise_on_low: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !din) |=> (level_q <= $past(level_q)));
  a_r3_no_fall_on_high: assert property (@(posedge clk) disable iff (rst)
    (sample_en && din) |=> (level_q >= $past(level_q)));
  a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_MAX) |=> (level_q != LVL_MIN));
  a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
    (level_q == LVL_MIN) |=> (level_q != LVL_MAX));
endmodule

// File: rtl/spike_lpf_trig.sv
module spike_lpf_trig
  import spike_lpf_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic         dout
);
  lpf_zone_e zone;
  logic      out_q;

  assign zone = lpf_zone_e'(level[W-1 -: 2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else begin
      unique case (zone)
        ZONE_HIGH: out_q <= 1'b1;
        ZONE_LOW:  out_q <= 1'b0;
        default:   out_q <= out_q;
      endcase
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/spike_lpf.sv
module spike_lpf #(
  parameter int CNT_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic din,
  output logic dout
);
  localparam int W = (CNT_W < 2) ? 2 : CNT_W;

  logic [W-1:0] dither;
  logic [W-1:0] level;
  logic         fb;

  spike_lpf_dither #(.W(W)) u_dither (
    .clk(clk), .rst(rst), .sample_en(sample_en), .dither(dither)
  );

  spike_lpf_ratemul #(.W(W)) u_ratemul (
    .level(level), .dither(dither), .fb(fb)
  );

  spike_lpf_integ #(.W(W)) u_integ (
    .clk(clk), .rst(rst), .sample_en(sample_en), .din(din), .fb(fb), .level(level)
  );

  spike_lpf_trig #(.W(W)) u_trig (
    .clk(clk), .rst(rst), .level(level), .dout(dout)
  );

  a_r6_rise_from_top: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> ($past(level[W-1 -: 2]) == 2'b11));
  a_r6_fall_from_bottom: assert property (@(posedge clk) disable iff (rst)
    $fell(dout) |-> ($past(level[W-1 -: 2]) == 2'b00));
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!dout && level == '0));
endmodule

// File: tb/spike_lpf_test.sv
module spike_lpf_test;
  localparam int W     = 6;
  localparam int FULL  = 1 << W;
  localparam int QUART = 1 << (W - 2);
  localparam int SETTL = 8 * FULL;
  localparam int MAXD  = 4 * FULL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic din = 1'b0;
  logic dout;

  int n_checks = 0;
  int n_fail = 0;
  int samp = 0;
  int t_rise = -1;
  int t_fall = -1;
  logic prev_out = 1'b0;
  logic flipped = 1'b0;

  spike_lpf #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .sample_en(sample_en), .din(din), .dout(dout)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    din = v; sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    @(posedge clk); #1;
    samp++;
    if (dout !== prev_out) begin
      flipped = 1'b1;
      if (dout) t_rise = samp; else t_fall = samp;
    end
    prev_out = dout;
  endtask

  task automatic drive(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sample_en = 1'b0; din = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    prev_out = dout;
  endtask

  task automatic test_reset();
    do_reset();
    check(dout == 1'b0, "R1 out after reset", dout, 0);
  endtask

  task automatic test_idle();
    int s0;
    @(negedge clk);
    din = 1'b1;
    repeat (600) @(negedge clk);
    check(dout == 1'b0, "R2 no change without sample_en", dout, 0);
    s0 = samp; t_rise = -1;
    drive(1'b1, MAXD);
    check(t_rise - s0 >= 3 * QUART, "R1/R6 rise delay from empty", t_rise - s0, 3 * QUART);
    drive(0, SETTL);
  endtask

  task automatic test_pos_spikes();
    drive(0, SETTL);
    for (int k = 0; k < 5; k++) begin
      flipped = 1'b0;
      drive(1, QUART - 1 - k);
      drive(0, SETTL / 2);
      check(!flipped && dout == 1'b0, "R7 positive spike rejected", dout, 0);
    end
  endtask

  task automatic test_neg_spikes();
    drive(1, SETTL);
    check(dout == 1'b1, "R7 settled high", dout, 1);
    for (int k = 0; k < 5; k++) begin
      flipped = 1'b0;
      drive(0, QUART - 1 - k);
      drive(1, SETTL / 2);
      check(!flipped && dout == 1'b1, "R7 negative spike rejected", dout, 1);
    end
    drive(0, SETTL);
  endtask

  task automatic test_long_pulse(input int len);
    int s0, dw, dl;
    drive(0, SETTL);
    s0 = samp; t_rise = -1; t_fall = -1;
    drive(1, len);
    drive(0, SETTL);
    dl = t_rise - s0;
    dw = (t_fall - t_rise) - len;
    check(dl >= 3 * QUART, "R6 rise needs top zone", dl, 3 * QUART);
    check(t_rise > 0 && dl <= MAXD, "R8 rise delay bounded", dl, MAXD);
    // R3/R4: width kept only if step rule and carry feedback are symmetric
    check(t_fall > t_rise && dw <= QUART && dw >= -QUART, "R8/R3/R4 width preserved",
          t_fall - t_rise, len);
  endtask

  task automatic test_saturation();
    int s1;
    drive(0, SETTL);
    drive(1, MAXD);
    flipped = 1'b0;
    drive(1, 40 * FULL);
    check(!flipped && dout == 1'b1, "R5 long high holds output", dout, 1);
    s1 = samp; t_fall = -1;
    drive(0, MAXD);
    check(t_fall > s1 && t_fall - s1 <= MAXD, "R5 recovery after saturation", t_fall - s1, MAXD);
  endtask

  task automatic test_reset_midhigh();
    int s0;
    drive(1, SETTL);
    check(dout == 1'b1, "R1 high before reset", dout, 1);
    do_reset();
    check(dout == 1'b0, "R1 reset clears output", dout, 0);
    s0 = samp; t_rise = -1;
    drive(1, MAXD);
    check(t_rise - s0 >= 3 * QUART, "R1 counter cleared by reset", t_rise - s0, 3 * QUART);
  endtask

  initial begin
    test_reset();
    test_idle();
    test_pos_spikes();
    test_neg_spikes();
    test_long_pulse(300);
    test_long_pulse(600);
    test_saturation();
    test_reset_midhigh();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule